// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Clear-on-Read Status

This block takes an asynchronous serial line that idles high and recovers 8-bit frames from it. Each frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit, and a high stop bit. The block is clocked by the system clock. A one-cycle enable, `tickEn`, pulses at eight times the bit rate and paces all sampling. The line first passes through a two-stage synchronizer. A falling level arms the start detector, and the start bit is confirmed half a bit later. After that, each bit is taken in the middle of its bit time.

Software sees two registers on a small bus. The first is a combined control and status word: parity enable, odd parity select, interrupt enable, receive-full, framing error, parity error and overrun. The second is the received byte. Both reads have side effects. Reading the status word clears the three error flags. Receive-full stays set until the byte itself is read. The interrupt is a level signal: it is high while the interrupt is enabled and a byte waits unread. If a handler never reads the byte, the interrupt stays high and marks no later arrival.

Top module: `oversampled_rx`

## Requirements
- R1: After reset the status word (`busSel`=0) reads 0x00, the data register (`busSel`=1) reads 0x00, and `irq` is low.
- R2: A frame with a high stop bit places its eight data bits, first received bit in bit 0, into the data register and sets receive-full (status bit 3).
- R3: A low level that has returned high by the fourth oversample tick after it was first seen is not a start bit. No byte is stored and no flag changes.
- R4: A status read returns the current flags, then clears framing error (bit 4), parity error (bit 5) and overrun (bit 6). Receive-full (bit 3) keeps its value.
- R5: A data read returns the stored byte and clears receive-full.
- R6: A stop bit sampled low sets framing error (bit 4). The byte is still stored and receive-full is still set.
- R7: After a stop bit sampled low, the FSM returns to idle at once. A line that stays low is then taken as the start of a new frame, which completes on its own and can raise a second framing error.
- R8: A frame that completes while receive-full is set sets overrun (bit 6) and is discarded. The data register keeps the earlier byte.
- R9: Control bit 0 enables a parity bit between the data and the stop bit, and control bit 1 selects odd (1) or even (0) parity. A parity bit that does not match sets parity error (bit 5). With parity off, no parity bit is expected and bit 5 never sets.
- R10: `irq` equals interrupt enable (control bit 2) AND receive-full. It stays high through status reads and falls only after a data read or when software clears the enable.
- R11: A write with `busSel`=0 loads control bits 2:0, which read back in status bits 2:0. Writes with `busSel`=1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Oversample enable, one cycle wide, at 8x the bit rate |
| rxIn | input | 1 | Asynchronous serial input, idles high |
| busSel | input | 1 | Register select: 0 control/status, 1 received data |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe; side effects take hold at the clock edge |
| busWdata | input | 3 | Write data for the control field |
| busRdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Level interrupt: receive-full while enabled |

## Verification
The bench aims at the start qualifier with a glitch two ticks long. A qualifier that skips the mid-bit recheck would store a byte that was never sent. It sends frames with a low stop bit and then holds the line low for a second frame time. A receiver that waited for a high level before it re-armed would show no overrun there, and one that dropped the framing flag would show no error. It reads status twice and data once after every frame. A design that cleared receive-full on a status read, or kept the error flags after one, fails there. It also checks overrun against the retained byte and the interrupt level across status and data reads.

// File: rtl/oversampled_rx_pkg.sv
package oversampled_rx_pkg;

  // Register select values on the bus
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_DATA   = 1'b1;

  // Control and status bit positions (software decodes these)
  localparam int CTL_PAR_EN   = 0;
  localparam int CTL_PAR_ODD  = 1;
  localparam int CTL_IRQ_EN   = 2;
  localparam int CTL_W        = 3;
  localparam int ST_FULL      = 3;
  localparam int ST_FRAME     = 4;
  localparam int ST_PARITY    = 5;
  localparam int ST_OVERRUN   = 6;
  localparam int ST_W         = 7;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearAcc;     // start confirmed: reset parity accumulator
    logic shiftBit;     // take one data bit
    logic sampleParity; // take the parity bit
    logic finishFrame;  // stop bit sampled: frame complete
  } rxStrobe_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rxState_t;

endpackage

// File: rtl/oversampled_rx_ctrl.sv
module oversampled_rx_ctrl
  import oversampled_rx_pkg::*;
#(
  parameter int OSR    = 8,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      rxBit,
  input  logic      parEn,
  output rxStrobe_t strobe
);

  localparam int TW   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int BW   = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int HALF = OSR / 2;
  localparam logic [TW-1:0] HALF_LAST = TW'(HALF - 1);
  localparam logic [TW-1:0] BIT_LAST  = TW'(OSR - 1);
  localparam logic [BW-1:0] DATA_LAST = BW'(DATA_W - 1);

  rxState_t      state, stateNext;
  logic [TW-1:0] tickCnt, tickCntNext;
  logic [BW-1:0] bitCnt, bitCntNext;

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    bitCntNext  = bitCnt;
    strobe      = '0;
    if (tickEn) begin
      unique case (state)
        RX_IDLE: begin
          if (!rxBit) begin
            stateNext   = RX_START;
            tickCntNext = '0;
          end
        end
        RX_START: begin
          if (tickCnt == HALF_LAST) begin
            tickCntNext = '0;
            if (!rxBit) begin
              stateNext       = RX_DATA;
              bitCntNext      = '0;
              strobe.clearAcc = 1'b1;
            end else begin
              stateNext = RX_IDLE;
            end
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (tickCnt == BIT_LAST) begin
            tickCntNext     = '0;
            strobe.shiftBit = 1'b1;
            if (bitCnt == DATA_LAST) begin
              stateNext = parEn ? RX_PARITY : RX_STOP;
            end else begin
              bitCntNext = bitCnt + 1'b1;
            end
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
        RX_PARITY: begin
          if (tickCnt == BIT_LAST) begin
            tickCntNext         = '0;
            strobe.sampleParity = 1'b1;
            stateNext           = RX_STOP;
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (tickCnt == BIT_LAST) begin
            tickCntNext        = '0;
            strobe.finishFrame = 1'b1;
            // back to idle at once: a low stop level can re-arm the start detector
            stateNext          = RX_IDLE;
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
        end
        default: stateNext = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      bitCnt  <= bitCntNext;
    end
  end

endmodule

// File: rtl/oversampled_rx_dp.sv
module oversampled_rx_dp
  import oversampled_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxAsync,
  output logic              rxBit,
  input  rxStrobe_t         strobe,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CTL_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq,
  output logic [ST_W-1:0]   statusWord,
  output logic [DATA_W-1:0] dataWord
);

  // Input synchronizer, reset to the idle (high) level
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= 1'b1;
        else if (s == 0) syncChain[s] <= rxAsync;
        else syncChain[s] <= syncChain[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign rxBit = syncChain[SYNC_STAGES-1];

  // Receive shift path
  logic [DATA_W-1:0] shiftReg;
  logic              parAcc;
  logic              parBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.clearAcc) begin
        parAcc <= 1'b0;
        parBit <= 1'b0;
      end
      if (strobe.shiftBit) begin
        shiftReg <= {rxBit, shiftReg[DATA_W-1:1]};
        parAcc   <= parAcc ^ rxBit;
      end
      if (strobe.sampleParity) parBit <= rxBit;
    end
  end

  // Register file
  logic [CTL_W-1:0]  ctrlReg;
  logic [DATA_W-1:0] dataReg;
  logic              rxFull, frameErr, parityErr, overrun;
  logic              statusRd, dataRd, frameDone, stopLow, parMismatch, loadByte;

  assign statusRd    = busRd && (busSel == SEL_STATUS);
  assign dataRd      = busRd && (busSel == SEL_DATA);
  assign frameDone   = strobe.finishFrame;
  assign stopLow     = frameDone && !rxBit;
  assign parMismatch = frameDone && ctrlReg[CTL_PAR_EN] &&
                       ((parAcc ^ parBit) != ctrlReg[CTL_PAR_ODD]);
  assign loadByte    = frameDone && (!rxFull || dataRd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      dataReg   <= '0;
      rxFull    <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (busWr && (busSel == SEL_STATUS)) ctrlReg <= busWdata;
      if (loadByte) dataReg <= shiftReg;
      // a new event in the same cycle wins over the read-clear
      rxFull    <= (rxFull & ~dataRd) | frameDone;
      frameErr  <= (frameErr & ~statusRd) | stopLow;
      parityErr <= (parityErr & ~statusRd) | parMismatch;
      overrun   <= (overrun & ~statusRd) | (frameDone & rxFull & ~dataRd);
    end
  end

  always_comb begin
    statusWord                 = '0;
    statusWord[CTL_W-1:0]      = ctrlReg;
    statusWord[ST_FULL]        = rxFull;
    statusWord[ST_FRAME]       = frameErr;
    statusWord[ST_PARITY]      = parityErr;
    statusWord[ST_OVERRUN]     = overrun;
  end

  assign dataWord = dataReg;
  assign irq      = ctrlReg[CTL_IRQ_EN] & rxFull;
  assign busRdata = (busSel == SEL_DATA) ? BUS_W'(dataReg) : BUS_W'(statusWord);

endmodule

// File: rtl/oversampled_rx.sv
module oversampled_rx
  import oversampled_rx_pkg::*;
#(
  parameter int OSR         = 8,
  parameter int DATA_W      = 8,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             rxIn,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [2:0]       busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             irq
);

  rxStrobe_t         strobe;
  logic              rxBit;
  logic [ST_W-1:0]   statusWord;
  logic [DATA_W-1:0] dataWord;

  oversampled_rx_ctrl #(
    .OSR    (OSR),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .rxBit  (rxBit),
    .parEn  (statusWord[CTL_PAR_EN]),
    .strobe (strobe)
  );

  oversampled_rx_dp #(
    .DATA_W      (DATA_W),
    .BUS_W       (BUS_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxAsync    (rxIn),
    .rxBit      (rxBit),
    .strobe     (strobe),
    .busSel     (busSel),
    .busWr      (busWr),
    .busRd      (busRd),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .irq        (irq),
    .statusWord (statusWord),
    .dataWord   (dataWord)
  );

endmodule

// File: rtl/oversampled_rx_chk.sv
module oversampled_rx_chk
  import oversampled_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic              busRd,
  input logic              irq,
  input logic [ST_W-1:0]   statusWord,
  input logic [DATA_W-1:0] dataWord,
  input rxStrobe_t         strobe
);

  logic statusRd, dataRd, ctrlWr;
  assign statusRd = busRd && (busSel == SEL_STATUS);
  assign dataRd   = busRd && (busSel == SEL_DATA);
  assign ctrlWr   = busWr && (busSel == SEL_STATUS);

  // R2: sequencer issues at most one strobe per cycle
  p_strobe_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clearAcc, strobe.shiftBit, strobe.sampleParity, strobe.finishFrame}));

  // R2: a completed frame leaves receive-full set
  p_full_after_frame_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finishFrame |=> statusWord[ST_FULL]);

  // R4: status read clears error flags when no frame completes alongside
  p_status_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strobe.finishFrame) |=> (statusWord[ST_OVERRUN:ST_FRAME] == '0));

  // R4: status read leaves receive-full alone
  p_full_survives_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && statusWord[ST_FULL]) |=> statusWord[ST_FULL]);

  // R5: data read clears receive-full
  p_data_clears_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !strobe.finishFrame) |=> !statusWord[ST_FULL]);

  // R8: held byte is not overwritten while unread
  p_held_byte_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[ST_FULL] && !dataRd) |=> $stable(dataWord));

  // R10: interrupt holds until data read or enable change
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !dataRd && !ctrlWr) |=> irq);

  // R11: control field changes only through a control write
  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(statusWord[CTL_W-1:0]));

endmodule

bind oversampled_rx oversampled_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busRd      (busRd),
  .irq        (irq),
  .statusWord (statusWord),
  .dataWord   (dataWord),
  .strobe     (strobe)
);

// File: tb/oversampled_rx_tb.sv
module oversampled_rx_tb;

  localparam int TICK_DIV = 4;
  localparam int NVEC     = 9;
  // {cfg[2:0], data[7:0], flipParity, stopLevel, expStatus[7:0], expData[7:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {3'b000, 8'hA5, 1'b0, 1'b1, 8'h08, 8'hA5},
    {3'b000, 8'h3C, 1'b0, 1'b0, 8'h18, 8'h3C},
    {3'b001, 8'h81, 1'b0, 1'b1, 8'h09, 8'h81},
    {3'b001, 8'h81, 1'b1, 1'b1, 8'h29, 8'h81},
    {3'b011, 8'h07, 1'b0, 1'b1, 8'h0B, 8'h07},
    {3'b011, 8'h07, 1'b1, 1'b1, 8'h2B, 8'h07},
    {3'b000, 8'hFF, 1'b0, 1'b1, 8'h08, 8'hFF},
    {3'b000, 8'h00, 1'b0, 1'b1, 8'h08, 8'h00},
    {3'b001, 8'h00, 1'b0, 1'b0, 8'h19, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       rxLine = 1'b1;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [2:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int divCnt = 0;
  bit done   = 1'b0;

  oversampled_rx u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .rxIn     (rxLine),
    .busSel   (busSel),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irq      (irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (divCnt == TICK_DIV - 1) begin
      divCnt <= 0;
      tickEn <= 1'b1;
    end else begin
      divCnt <= divCnt + 1;
      tickEn <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n) @(posedge clk iff tickEn);
    #1;
  endtask

  task automatic driveBit(input logic v, input int ticks);
    rxLine = v;
    waitTicks(ticks);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic parOn, input logic parVal,
                           input logic stopVal, input int extraLow);
    waitTicks(1);
    driveBit(1'b0, 8);
    for (int i = 0; i < 8; i++) driveBit(d[i], 8);
    if (parOn) driveBit(parVal, 8);
    driveBit(stopVal, 8);
    if (extraLow > 0) driveBit(1'b0, extraLow);
    rxLine = 1'b1;
    waitTicks(16);
  endtask

  task automatic regWrite(input logic sel, input logic [2:0] v);
    @(negedge clk);
    busSel = sel; busWdata = v; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRead(input logic sel, output logic [7:0] v);
    @(negedge clk);
    busSel = sel; busRd = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    regRead(1'b0, rd); check("R1 status after reset", rd, 8'h00);
    regRead(1'b1, rd); check("R1 data after reset", rd, 8'h00);
    check("R1 irq after reset", {7'b0, irq}, 8'h00);

    // Table walk: R2 R4 R5 R6 R9
    for (int k = 0; k < NVEC; k++) begin
      logic [2:0] cfg;
      logic [7:0] dat, expS, expD;
      logic flip, stopV, parV;
      {cfg, dat, flip, stopV, expS, expD} = VEC[k];
      parV = (^dat) ^ cfg[1] ^ flip;
      regWrite(1'b0, cfg);
      sendFrame(dat, cfg[0], parV, stopV, 0);
      regRead(1'b0, rd); check($sformatf("R2/R6/R9 status vec %0d", k), rd, expS);
      regRead(1'b0, rd); check($sformatf("R4 status reread vec %0d", k), rd, expS & 8'h0F);
      regRead(1'b1, rd); check($sformatf("R5 data vec %0d", k), rd, expD);
      regRead(1'b0, rd); check($sformatf("R5 full cleared vec %0d", k), rd, {5'b0, cfg});
    end

    // R3 short low glitch is not a start
    regWrite(1'b0, 3'b000);
    waitTicks(1);
    driveBit(1'b0, 2);
    rxLine = 1'b1;
    waitTicks(120);
    regRead(1'b0, rd); check("R3 glitch ignored status", rd, 8'h00);

    // R8 overrun keeps first byte
    sendFrame(8'h11, 1'b0, 1'b0, 1'b1, 0);
    sendFrame(8'h22, 1'b0, 1'b0, 1'b1, 0);
    regRead(1'b0, rd); check("R8 overrun status", rd, 8'h48);
    regRead(1'b1, rd); check("R8 retained byte", rd, 8'h11);
    regRead(1'b0, rd); check("R8 flags cleared", rd, 8'h00);

    // R7 low stop then held low: second frame from the low level
    sendFrame(8'h00, 1'b0, 1'b0, 1'b0, 76);
    regRead(1'b0, rd); check("R7 second frame framing+overrun", rd, 8'h58);
    regRead(1'b1, rd); check("R7 stored byte", rd, 8'h00);

    // R10 level interrupt
    regWrite(1'b0, 3'b100);
    check("R10 irq idle", {7'b0, irq}, 8'h00);
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b1, 0);
    @(negedge clk); check("R10 irq on full", {7'b0, irq}, 8'h01);
    regRead(1'b0, rd); check("R10 status with irq", rd, 8'h0C);
    @(negedge clk); check("R10 irq survives status read", {7'b0, irq}, 8'h01);
    regRead(1'b1, rd); check("R10 data", rd, 8'h5A);
    @(negedge clk); check("R10 irq after data read", {7'b0, irq}, 8'h00);
    regWrite(1'b0, 3'b000);
    sendFrame(8'hC3, 1'b0, 1'b0, 1'b1, 0);
    @(negedge clk); check("R10 irq masked", {7'b0, irq}, 8'h00);
    regRead(1'b1, rd); check("R10 masked data", rd, 8'hC3);

    // R11 control field and ignored data-address write
    regWrite(1'b0, 3'b111);
    regRead(1'b0, rd); check("R11 control readback", rd, 8'h07);
    regWrite(1'b1, 3'b000);
    regRead(1'b0, rd); check("R11 data write ignored status", rd, 8'h07);
    regRead(1'b1, rd); check("R11 data write ignored data", rd, 8'hC3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule